// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers up to 128 level-sensitive interrupt lines, grouped into banks of 32, and presents them to a processor through one interrupt request pin. Each bank has a mask word. Software can write the mask word whole. It can also change single bits through two strobe-style words: one clears mask bits and one sets them. A read-only word per bank shows which lines are both asserted and enabled.

When no interrupt is held, the controller picks the lowest-numbered enabled and asserted line. One clock later it latches that number into the active-number register. The number stays put until software writes an acknowledge to the control register. One cycle after the acknowledge, the controller chooses again from the lines pending at that time.

A system configuration register can start a soft reset. The soft reset runs for a fixed number of cycles. While it runs, every line is disabled, the held number is dropped and the configuration words are cleared. A status flag tells software when the soft reset has finished.

Access uses a simple register bus with separate read and write strobes. The bus has no back-pressure: a write takes effect on the clock edge where its strobe is sampled. Read data appears on the cycle after the read strobe and holds until the next read. These are control registers and carry no data stream, so there is no valid/ready handshake. NUM_SRC must be a multiple of 32.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all mask bits read 1, `irq_out` is 0 and the active-number register (0x40) reads 0. The status register (0x14) reads 1 in bit 0. The revision register (0x00) reads the REV parameter in bits 7:0, with the major version in bits 7:4 and the minor version in bits 3:0.
- R2: Bank n has a mask word at 0x84+0x20·n that is written whole and read back. Its clear word at 0x88+0x20·n enables every line whose written bit is 1. Its set word at 0x8C+0x20·n disables every line whose written bit is 1. A 0 bit in a clear or set write leaves that mask bit unchanged.
- R3: Bank n's pending word at 0x98+0x20·n reads the level inputs of that bank ANDed with the inverse of its mask.
- R4: `irq_out` is 1 in any cycle where an active number is held or any pending bit is set, and 0 otherwise.
- R5: When no number is held and some line is pending, the lowest-numbered pending line is latched at the next clock edge. The active-number register returns it in bits 6:0 and reads 0 when nothing is held.
- R6: A held number does not change when lines rise or fall until an acknowledge is written, even if its own line deasserts or a lower-numbered line becomes pending.
- R7: A write to the control register (0x48) with bit 0 set drops the held number, including a stale one whose line is already gone. The lowest pending line is latched one cycle later. A control write with bit 0 clear has no effect.
- R8: A write to sysconfig (0x10) with bit 1 set starts a soft reset lasting RST_CYCLES cycles. During the soft reset, status bit 0 reads 0 and every bus write is ignored. The soft reset sets all mask bits, drops the held number and clears the sysconfig, protection, idle and threshold words. Status bit 0 returns to 1 when it finishes.
- R9: The following fields hold what is written and read it back, with all other bits reading 0: sysconfig bit 0 (auto-idle), protection (0x4C) bit 0, idle (0x50) bits 1:0, threshold (0x68) bits 7:0.
- R10: Reads of unmapped addresses, of the control register and of the clear and set words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_lvl | input | NUM_SRC | Level-sensitive interrupt lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
An acknowledge and a newly rising line can land in the same cycle. That cycle decides whether the controller re-chooses from the lines as they stand after the acknowledge. The bench provokes it directly: with line 40 held, it writes the acknowledge on the same clock edge that line 5 rises. It then expects the request to stay high across the gap and expects 5, not 40, on the next read. A soft reset that starts while a number is held is the second collision. The bench expects the held number gone, the request low and a mask write issued during the soft reset to have had no effect.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int BANK_W = 32;
  localparam int ACT_W  = 7;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_REV  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SYSC = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_SYSS = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_ACT  = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_PROT = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_IDLE = 12'h050;
  localparam logic [ADDR_W-1:0] OFS_THR  = 12'h068;

  localparam logic [ADDR_W-1:0] BANK_BASE = 12'h080;
  localparam int                BANK_STRIDE = 32;
  localparam logic [4:0] SUB_MASK = 5'h04;
  localparam logic [4:0] SUB_CLR  = 5'h08;
  localparam logic [4:0] SUB_SET  = 5'h0C;
  localparam logic [4:0] SUB_PEND = 5'h18;
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         force_all,
  input  logic         wr_whole,
  input  logic         wr_clr,
  input  logic         wr_set,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] mask,
  output logic [W-1:0] pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask <= '1;
    else if (force_all) mask <= '1;
    else if (wr_whole)  mask <= wdata;
    else if (wr_clr)    mask <= mask & ~wdata;
    else if (wr_set)    mask <= mask | wdata;
  end

  assign pend = lvl & ~mask;
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int N  = 96,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_srst_seq.sv
module irq_srst_seq #(
  parameter int CYC = 8,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int          NUM_SRC    = 96,
  parameter int          RST_CYCLES = 8,
  parameter logic [7:0]  REV        = 8'h21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_lvl,
  output logic               irq_out
);
  localparam int NB = NUM_SRC / BANK_W;
  localparam int IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ADDR_W-1:0] BANK_END = ADDR_W'(32'(BANK_BASE) + NB * BANK_STRIDE);

  logic              srst_busy, srst_start, wr_ok, ack_hit;
  logic              in_bank;
  logic [ADDR_W-1:0] boff;
  logic [6:0]        bsel;
  logic [4:0]        sub;
  logic [NB-1:0][BANK_W-1:0] mask_w, pend_w;
  logic [NUM_SRC-1:0] pend_all;
  logic               pend_any;
  logic [IW-1:0]      pick_idx;
  logic               act_valid;
  logic [ACT_W-1:0]   act_num;
  logic               autoidle, prot;
  logic [1:0]         idle_q;
  logic [7:0]         thr_q;
  logic [31:0]        rd_mux;

  assign wr_ok      = bus_wr && !srst_busy;
  assign ack_hit    = wr_ok && (bus_addr == OFS_CTRL) && bus_wdata[0];
  assign srst_start = wr_ok && (bus_addr == OFS_SYSC) && bus_wdata[1];

  assign in_bank = (bus_addr >= BANK_BASE) && (bus_addr < BANK_END);
  assign boff    = bus_addr - BANK_BASE;
  assign bsel    = boff[11:5];
  assign sub     = boff[4:0];

  irq_srst_seq #(.CYC(RST_CYCLES)) srst_i (
    .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(srst_busy)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = wr_ok && in_bank && (bsel == 7'(b));
    irq_mask_bank #(.W(BANK_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_all(srst_busy),
      .wr_whole (hit && (sub == SUB_MASK)),
      .wr_clr   (hit && (sub == SUB_CLR)),
      .wr_set   (hit && (sub == SUB_SET)),
      .wdata    (bus_wdata),
      .lvl      (irq_lvl[b*BANK_W +: BANK_W]),
      .mask     (mask_w[b]),
      .pend     (pend_w[b])
    );
    assign pend_all[b*BANK_W +: BANK_W] = pend_w[b];
  end

  irq_low_pick #(.N(NUM_SRC)) pick_i (
    .vec(pend_all), .found(pend_any), .idx(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_num   <= '0;
    end else if (srst_busy) begin
      act_valid <= 1'b0;
      act_num   <= '0;
    end else if (ack_hit) begin
      act_valid <= 1'b0;
    end else if (!act_valid && pend_any) begin
      act_valid <= 1'b1;
      act_num   <= ACT_W'(pick_idx);
    end
  end

  assign irq_out = act_valid || pend_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst_busy) begin
      autoidle <= 1'b0;
      prot     <= 1'b0;
      idle_q   <= '0;
      thr_q    <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        OFS_SYSC: autoidle <= bus_wdata[0];
        OFS_PROT: prot     <= bus_wdata[0];
        OFS_IDLE: idle_q   <= bus_wdata[1:0];
        OFS_THR:  thr_q    <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_REV:  rd_mux = {24'b0, REV};
      OFS_SYSC: rd_mux = {30'b0, srst_busy, autoidle};
      OFS_SYSS: rd_mux = {31'b0, !srst_busy};
      OFS_ACT:  rd_mux = {25'b0, act_valid ? act_num : 7'd0};
      OFS_PROT: rd_mux = {31'b0, prot};
      OFS_IDLE: rd_mux = {30'b0, idle_q};
      OFS_THR:  rd_mux = {24'b0, thr_q};
      default:  rd_mux = '0;
    endcase
    if (in_bank) begin
      for (int b = 0; b < NB; b++) begin
        if (bsel == 7'(b)) begin
          if (sub == SUB_MASK)      rd_mux = mask_w[b];
          else if (sub == SUB_PEND) rd_mux = pend_w[b];
          else                      rd_mux = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_SRC = 96
) (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_out,
  input logic       act_valid,
  input logic [6:0] act_num,
  input logic       ack_hit,
  input logic       srst_busy,
  input logic       pend_any
);
  AST_NO_SPURIOUS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |=> !act_valid); // R5

  AST_LATCH_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_valid && pend_any && !ack_hit && !srst_busy) |=> act_valid); // R5

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !ack_hit && !srst_busy) |=> (act_valid && $stable(act_num))); // R6

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && act_valid) |=> !act_valid); // R7

  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> !irq_out); // R8

  AST_ACT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> (32'(act_num) < NUM_SRC)); // R5
endmodule

bind banked_irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .act_valid(act_valid),
  .act_num  (act_num),
  .ack_hit  (ack_hit),
  .srst_busy(srst_busy),
  .pend_any (pend_any)
);

// File: tb/banked_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb_top;
  localparam int NS = 96;
  localparam int NB = NS / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] lvl = '0;
  logic          irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] m_mask [NB];

  always #2.5 clk = ~clk;

  banked_irq_ctrl #(.NUM_SRC(NS), .RST_CYCLES(8), .REV(8'h21)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lvl(lvl), .irq_out(irq_out)
  );

  function automatic logic [11:0] a_mask(int b); return 12'(12'h084 + 32 * b); endfunction
  function automatic logic [11:0] a_clr(int b);  return 12'(12'h088 + 32 * b); endfunction
  function automatic logic [11:0] a_set(int b);  return 12'(12'h08C + 32 * b); endfunction
  function automatic logic [11:0] a_pend(int b); return 12'(12'h098 + 32 * b); endfunction

  function automatic int lowest(logic [NS-1:0] v);
    for (int i = 0; i < NS; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [NS-1:0] exp_pend();
    logic [NS-1:0] r;
    for (int b = 0; b < NB; b++) r[b*32 +: 32] = lvl[b*32 +: 32] & ~m_mask[b];
    return r;
  endfunction

  function automatic logic [31:0] exp_act();
    int lo = lowest(exp_pend());
    return (lo < 0) ? 32'd0 : 32'(lo);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack();
    bus_write(12'h048, 32'h1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog got=%08h exp=%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r;
    int lo, lo2;
    r = $urandom(32'h5EED1234);
    for (int b = 0; b < NB; b++) m_mask[b] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 32'd0);
    bus_read(12'h000, d); check("R1 revision", d, 32'h21);
    bus_read(12'h014, d); check("R1 status", d, 32'h1);
    bus_read(12'h040, d); check("R1 active", d, 32'h0);
    for (int b = 0; b < NB; b++) begin
      bus_read(a_mask(b), d); check("R1 mask", d, 32'hFFFF_FFFF);
    end

    // R2 directed set/clear/whole
    bus_write(a_clr(1), 32'h0000_00F0);
    bus_read(a_mask(1), d); check("R2 clear", d, ~32'h0000_00F0);
    bus_write(a_set(1), 32'h0000_0010);
    bus_read(a_mask(1), d); check("R2 set", d, ~32'h0000_00E0);
    bus_write(a_set(1), 32'h0);
    bus_write(a_clr(1), 32'h0);
    bus_read(a_mask(1), d); check("R2 zero bits no effect", d, ~32'h0000_00E0);
    bus_write(a_mask(2), 32'h1234_5678);
    bus_read(a_mask(2), d); check("R2 whole write", d, 32'h1234_5678);
    m_mask[1] = ~32'h0000_00E0; m_mask[2] = 32'h1234_5678;

    // random phase
    for (int it = 0; it < 24; it++) begin
      @(negedge clk); lvl = '0;
      ack();
      for (int b = 0; b < NB; b++) begin
        logic [31:0] m, c, s;
        m = $urandom; c = $urandom; s = $urandom & $urandom;
        bus_write(a_mask(b), m); m_mask[b] = m;
        bus_write(a_clr(b), c);  m_mask[b] = m_mask[b] & ~c;
        bus_write(a_set(b), s);  m_mask[b] = m_mask[b] | s;
        bus_read(a_mask(b), d); check("R2 random mask", d, m_mask[b]);
      end
      @(negedge clk);
      for (int b = 0; b < NB; b++) lvl[b*32 +: 32] = $urandom & $urandom & $urandom;
      @(negedge clk);
      check("R4 irq_out", {31'b0, irq_out}, {31'b0, |exp_pend()});
      for (int b = 0; b < NB; b++) begin
        logic [NS-1:0] ep;
        ep = exp_pend();
        bus_read(a_pend(b), d); check("R3 pending", d, ep[b*32 +: 32]);
      end
      bus_read(12'h040, d); check("R5 active lowest", d, exp_act());
      lo = lowest(exp_pend());
      if (lo >= 0) begin
        @(negedge clk); lvl[lo] = 1'b0;
        bus_read(12'h040, d); check("R6 held after deassert", d, 32'(lo));
        ack();
        bus_read(12'h040, d); check("R7 re-chosen after ack", d, exp_act());
      end
    end

    // collision: acknowledge on the same edge a lower line rises
    @(negedge clk); lvl = '0;
    ack();
    for (int b = 0; b < NB; b++) begin
      bus_write(a_clr(b), 32'hFFFF_FFFF); m_mask[b] = '0;
    end
    @(negedge clk); lvl[40] = 1'b1;
    @(negedge clk);
    bus_read(12'h040, d); check("R5 latch 40", d, 32'd40);
    @(negedge clk); lvl[10] = 1'b1;
    bus_read(12'h040, d); check("R6 lower line ignored", d, 32'd40);
    @(negedge clk); lvl[10] = 1'b0;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h048; bus_wdata = 32'h1; lvl[5] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R4 irq across ack gap", {31'b0, irq_out}, 32'd1);
    @(negedge clk);
    bus_read(12'h040, d); check("R7 collision picks 5", d, 32'd5);
    bus_write(12'h048, 32'h2);
    @(negedge clk);
    bus_read(12'h040, d); check("R7 bit0 clear no effect", d, 32'd5);

    // stale held number: mask its line, then acknowledge
    bus_write(a_set(0), 32'h0000_0020);
    bus_read(12'h040, d); check("R6 held while masked", d, 32'd5);
    ack();
    bus_read(12'h040, d); check("R7 stale cleared", d, 32'd40);
    bus_write(a_clr(0), 32'h0000_0020);

    // R9 config readback
    bus_write(12'h04C, 32'hFFFF_FFFF); bus_read(12'h04C, d); check("R9 protection", d, 32'h1);
    bus_write(12'h050, 32'hFFFF_FFFF); bus_read(12'h050, d); check("R9 idle", d, 32'h3);
    bus_write(12'h068, 32'h0000_01FF); bus_read(12'h068, d); check("R9 threshold", d, 32'hFF);
    bus_write(12'h010, 32'h0000_0001); bus_read(12'h010, d); check("R9 autoidle", d, 32'h1);

    // R10 unmapped and write-only reads
    bus_read(12'h020, d); check("R10 unmapped low", d, 32'h0);
    bus_read(12'h300, d); check("R10 unmapped high", d, 32'h0);
    bus_read(12'h048, d); check("R10 control reads 0", d, 32'h0);
    bus_read(a_clr(0), d); check("R10 clear word reads 0", d, 32'h0);

    // R8 soft reset while a number is held
    bus_write(12'h010, 32'h0000_0002);
    bus_read(12'h014, d); check("R8 status busy", d, 32'h0);
    bus_write(a_clr(0), 32'hFFFF_FFFF);
    begin
      int n = 0;
      d = 0;
      while (d[0] == 1'b0 && n < 100) begin
        bus_read(12'h014, d); n++;
      end
      check("R8 status done", d, 32'h1);
    end
    bus_read(a_mask(0), d); check("R8 masks set, write ignored", d, 32'hFFFF_FFFF);
    bus_read(12'h040, d); check("R8 active dropped", d, 32'h0);
    check("R8 irq_out low", {31'b0, irq_out}, 32'd0);
    bus_read(12'h04C, d); check("R8 protection cleared", d, 32'h0);
    bus_read(12'h068, d); check("R8 threshold cleared", d, 32'h0);
    bus_read(12'h010, d); check("R8 sysconfig cleared", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule